// File: doc/BRIEF.md
# Two-Slot Execution List Tracker

This block follows the submissions made to one GPU engine's execution list. It keeps two slots, each holding a pair of context descriptors. A descriptor is a valid flag, a context id and a context base address. The block records which slot is running, which slot (if any) is pending, and which element of the running pair is the running context.

Requests arrive on two valid/ready streams:
- A schedule-in request carries a new descriptor pair.
- A schedule-out request names the context that has just finished.

Both streams accept a request only when no status event is waiting to leave, so at most one request is taken per cycle. Schedule-out has priority when both are offered. A request that the tracker rejects is still consumed, and it raises a one-cycle error pulse.

The tracker compares the incoming and running descriptors. From that it decides which kind of event to send: idle-to-active, element switch, active-to-idle, or lite restore with preemption. Each event goes out on a valid/ready event stream towards a separate status-buffer writer. When the event sink holds ready low, the current event stays stable and both request streams stall. The status image (slot pointers, per-slot active and valid bits, running context id, queue-full) is kept on plain output pins.

Top module: `exec_slot_tracker`

## Requirements
- R1: Two contexts count as the same only when both context id and base address are equal; a schedule-out whose id matches the running context but whose base does not is rejected.
- R2: With nothing running, an accepted schedule-in makes the new slot running with element 0 as running context and emits an event with flags 0x01 (idle-to-active), context id 0 and irq 1.
- R3: With a slot running and no pending slot, a schedule-in is a lite restore when either (a) running element 1 is valid, equals new element 0 and element 1 is the running context, or (b) running element 1 is invalid and running element 0 equals new element 0. The new slot then runs immediately from element 0, and an event with flags 0x22 (lite restore 0x20, preempted 0x02), new element 0's id and irq 1 is emitted.
- R4: Any other schedule-in while a slot runs and none is pending stores the pair as the pending slot, sets queue-full and emits no event.
- R5: A schedule-in while queue-full is set is rejected: it raises the error pulse and changes neither slots nor status. Otherwise the pair is written into the slot whose index equals the status write pointer.
- R6: A schedule-out of running element 0 while element 1 is valid makes element 1 the running context and emits flags 0x14 (context complete 0x10, element switch 0x04) with the finished id and irq 1.
- R7: A schedule-out of the last valid element with no pending slot leaves nothing running and emits flags 0x18 (context complete 0x10, active-to-idle 0x08) with the finished id and irq 1. All active and valid bits clear and the status context id becomes 0.
- R8: The same schedule-out with a pending slot emits flags 0x18 with irq 0, then an event with flags 0x01, id 0 and irq 1. The pending slot becomes running from element 0 and queue-full clears.
- R9: The current-pointer bit equals the running slot index and the write-pointer bit is its inverse. Only the running slot's active and valid bits are set, and the status context id is the running context's id. Both pointer bits keep their last values while nothing runs.
- R10: A schedule-out naming a context other than the running one, or arriving while nothing runs, raises the error pulse, emits nothing and changes no state.
- R11: Both request readies are low while an event is outstanding. An event held by back-pressure keeps its flags, id and irq stable. When both requests are offered together, schedule-out is taken first.
- R12: After reset no slot is running or pending, all status bits and the context id are 0, no event is valid and both readies are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sin_valid | input | 1 | Schedule-in request offered |
| sin_ready | output | 1 | Schedule-in request can be taken |
| sin_e0_valid | input | 1 | New element 0 valid flag |
| sin_e0_id | input | ID_W | New element 0 context id |
| sin_e0_base | input | BASE_W | New element 0 base address |
| sin_e1_valid | input | 1 | New element 1 valid flag |
| sin_e1_id | input | ID_W | New element 1 context id |
| sin_e1_base | input | BASE_W | New element 1 base address |
| sout_valid | input | 1 | Schedule-out request offered |
| sout_ready | output | 1 | Schedule-out request can be taken |
| sout_id | input | ID_W | Finished context id |
| sout_base | input | BASE_W | Finished context base address |
| evt_valid | output | 1 | Status event offered |
| evt_ready | input | 1 | Status-buffer writer takes the event |
| evt_flags | output | 6 | Event flags (0x01 idle-to-active, 0x02 preempted, 0x04 element switch, 0x08 active-to-idle, 0x10 context complete, 0x20 lite restore) |
| evt_ctx_id | output | ID_W | Context id carried by the event |
| evt_irq | output | 1 | 1 when the event should raise an interrupt now |
| req_err | output | 1 | One-cycle pulse for a rejected request |
| st_cur_ptr | output | 1 | Running slot index |
| st_wr_ptr | output | 1 | Slot index for the next schedule-in |
| st_el0_active | output | 1 | Slot 0 is running |
| st_el0_valid | output | 1 | Slot 0 holds the running list |
| st_el1_active | output | 1 | Slot 1 is running |
| st_el1_valid | output | 1 | Slot 1 holds the running list |
| st_ctx_id | output | ID_W | Running context id, 0 when idle |
| st_queue_full | output | 1 | A pending slot exists |

## Verification
A request is taken at the rising edge where its valid and ready are both high. The slot state, the status pins, the error pulse and the first event are all registered at that same edge, so each is due one edge after acceptance. A second event from R8 appears at the edge that consumes the first one. The bench drives inputs 1 ns after a rising edge and samples every output at the following falling edge. Its scoreboard monitor pops an expected event only at a falling edge where valid and ready are both high, which is exactly the cycle whose next edge completes that transfer.

// File: rtl/est_pkg.sv
package est_pkg;

  localparam int FLG_W = 6;

  localparam logic [FLG_W-1:0] EV_IDLE_TO_ACT = 6'h01;
  localparam logic [FLG_W-1:0] EV_PREEMPTED   = 6'h02;
  localparam logic [FLG_W-1:0] EV_ELEM_SWITCH = 6'h04;
  localparam logic [FLG_W-1:0] EV_ACT_TO_IDLE = 6'h08;
  localparam logic [FLG_W-1:0] EV_CTX_DONE    = 6'h10;
  localparam logic [FLG_W-1:0] EV_LITE        = 6'h20;

  typedef struct packed {
    logic run_valid;
    logic run_idx;
    logic run_sel;
    logic pend_valid;
    logic pend_idx;
  } trk_state_t;

endpackage

// File: rtl/est_slot_store.sv
module est_slot_store #(
  parameter int DESC_W = 37
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_idx,
  input  logic [DESC_W-1:0] wr_e0,
  input  logic [DESC_W-1:0] wr_e1,
  input  logic              rd_idx,
  output logic [DESC_W-1:0] rd_e0,
  output logic [DESC_W-1:0] rd_e1
);
  localparam int NSLOT = 2;

  logic [NSLOT-1:0][DESC_W-1:0] e0_q;
  logic [NSLOT-1:0][DESC_W-1:0] e1_q;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        e0_q[s] <= '0;
        e1_q[s] <= '0;
      end else if (wr_en && (wr_idx == s[0])) begin
        e0_q[s] <= wr_e0;
        e1_q[s] <= wr_e1;
      end
    end
  end

  assign rd_e0 = e0_q[rd_idx];
  assign rd_e1 = e1_q[rd_idx];

endmodule

// File: rtl/est_decide.sv
module est_decide
  import est_pkg::*;
#(
  parameter int ID_W   = 16,
  parameter int BASE_W = 20
) (
  input  trk_state_t            st,
  input  logic                  wr_ptr,
  input  logic                  take_in,
  input  logic                  take_out,
  input  logic [ID_W+BASE_W-1:0] new_key0,
  input  logic [ID_W+BASE_W-1:0] out_key,
  input  logic [ID_W+BASE_W-1:0] run_key0,
  input  logic                  run_v1,
  input  logic [ID_W+BASE_W-1:0] run_key1,
  output trk_state_t            st_n,
  output logic                  store_we,
  output logic                  ev0_v,
  output logic [FLG_W+ID_W:0]   ev0,
  output logic                  ev1_v,
  output logic [FLG_W+ID_W:0]   ev1,
  output logic                  err
);
  localparam int KEY_W = ID_W + BASE_W;

  function automatic logic [ID_W-1:0] id_of(input logic [KEY_W-1:0] k);
    return k[KEY_W-1:BASE_W];
  endfunction

  logic [KEY_W-1:0] run_cur_key;
  logic             out_hits_run;
  logic             lite_a;
  logic             lite_b;

  assign run_cur_key  = st.run_sel ? run_key1 : run_key0;
  assign out_hits_run = st.run_valid && (out_key == run_cur_key);
  assign lite_a = run_v1 && (run_key1 == new_key0) && st.run_sel;
  assign lite_b = !run_v1 && (run_key0 == new_key0);

  always_comb begin
    st_n     = st;
    store_we = 1'b0;
    ev0_v    = 1'b0;
    ev0      = '0;
    ev1_v    = 1'b0;
    ev1      = '0;
    err      = 1'b0;
    if (take_out) begin
      if (!out_hits_run) begin
        err = 1'b1;
      end else if (run_v1 && (run_key0 == out_key)) begin
        st_n.run_sel = 1'b1;
        ev0_v = 1'b1;
        ev0   = {1'b1, EV_CTX_DONE | EV_ELEM_SWITCH, id_of(out_key)};
      end else begin
        st_n.run_valid  = st.pend_valid;
        st_n.run_idx    = st.pend_valid ? st.pend_idx : st.run_idx;
        st_n.run_sel    = 1'b0;
        st_n.pend_valid = 1'b0;
        ev0_v = 1'b1;
        ev0   = {!st.pend_valid, EV_CTX_DONE | EV_ACT_TO_IDLE, id_of(out_key)};
        if (st.pend_valid) begin
          ev1_v = 1'b1;
          ev1   = {1'b1, EV_IDLE_TO_ACT, {ID_W{1'b0}}};
        end
      end
    end else if (take_in) begin
      if (st.pend_valid) begin
        err = 1'b1;
      end else begin
        store_we = 1'b1;
        if (!st.run_valid) begin
          st_n.run_valid = 1'b1;
          st_n.run_idx   = wr_ptr;
          st_n.run_sel   = 1'b0;
          ev0_v = 1'b1;
          ev0   = {1'b1, EV_IDLE_TO_ACT, {ID_W{1'b0}}};
        end else if (lite_a || lite_b) begin
          st_n.run_idx = wr_ptr;
          st_n.run_sel = 1'b0;
          ev0_v = 1'b1;
          ev0   = {1'b1, EV_LITE | EV_PREEMPTED, id_of(new_key0)};
        end else begin
          st_n.pend_valid = 1'b1;
          st_n.pend_idx   = wr_ptr;
        end
      end
    end
  end

endmodule

// File: rtl/est_evt_out.sv
module est_evt_out #(
  parameter int EV_W = 23
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ld,
  input  logic [EV_W-1:0] ld_ev0,
  input  logic            ld_ev1_v,
  input  logic [EV_W-1:0] ld_ev1,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [EV_W-1:0] out_data
);
  logic            v0_q, v1_q;
  logic [EV_W-1:0] d0_q, d1_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v0_q <= 1'b0;
      v1_q <= 1'b0;
      d0_q <= '0;
      d1_q <= '0;
    end else if (ld && !v0_q) begin
      v0_q <= 1'b1;
      d0_q <= ld_ev0;
      v1_q <= ld_ev1_v;
      d1_q <= ld_ev1;
    end else if (v0_q && out_ready) begin
      v0_q <= v1_q;
      d0_q <= d1_q;
      v1_q <= 1'b0;
    end
  end

  assign out_valid = v0_q;
  assign out_data  = d0_q;

  // R8: a queued follow-up event never stands without a head event
  a_r8_second_behind_first: assert property (@(posedge clk) disable iff (!rst_n)
    v1_q |-> v0_q);

endmodule

// File: rtl/exec_slot_tracker.sv
module exec_slot_tracker
  import est_pkg::*;
#(
  parameter int ID_W   = 16,
  parameter int BASE_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sin_valid,
  output logic              sin_ready,
  input  logic              sin_e0_valid,
  input  logic [ID_W-1:0]   sin_e0_id,
  input  logic [BASE_W-1:0] sin_e0_base,
  input  logic              sin_e1_valid,
  input  logic [ID_W-1:0]   sin_e1_id,
  input  logic [BASE_W-1:0] sin_e1_base,
  input  logic              sout_valid,
  output logic              sout_ready,
  input  logic [ID_W-1:0]   sout_id,
  input  logic [BASE_W-1:0] sout_base,
  output logic              evt_valid,
  input  logic              evt_ready,
  output logic [5:0]        evt_flags,
  output logic [ID_W-1:0]   evt_ctx_id,
  output logic              evt_irq,
  output logic              req_err,
  output logic              st_cur_ptr,
  output logic              st_wr_ptr,
  output logic              st_el0_active,
  output logic              st_el0_valid,
  output logic              st_el1_active,
  output logic              st_el1_valid,
  output logic [ID_W-1:0]   st_ctx_id,
  output logic              st_queue_full
);
  localparam int KEY_W  = ID_W + BASE_W;
  localparam int DESC_W = 1 + KEY_W;
  localparam int EV_W   = 1 + FLG_W + ID_W;

  trk_state_t        st_q, st_n;
  logic              cur_ptr_q, wr_ptr_q;
  logic              err_q;
  logic              busy;
  logic              take_in, take_out;
  logic [DESC_W-1:0] run_e0, run_e1;
  logic              store_we;
  logic              ev0_v, ev1_v, dec_err;
  logic [EV_W-1:0]   ev0, ev1, ev_out;

  assign busy       = evt_valid;
  assign sout_ready = !busy;
  assign sin_ready  = !busy && !sout_valid;
  assign take_out   = sout_valid && sout_ready;
  assign take_in    = sin_valid && sin_ready;

  est_slot_store #(.DESC_W(DESC_W)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (store_we),
    .wr_idx (wr_ptr_q),
    .wr_e0  ({sin_e0_valid, sin_e0_id, sin_e0_base}),
    .wr_e1  ({sin_e1_valid, sin_e1_id, sin_e1_base}),
    .rd_idx (st_q.run_idx),
    .rd_e0  (run_e0),
    .rd_e1  (run_e1)
  );

  est_decide #(.ID_W(ID_W), .BASE_W(BASE_W)) u_decide (
    .st       (st_q),
    .wr_ptr   (wr_ptr_q),
    .take_in  (take_in),
    .take_out (take_out),
    .new_key0 ({sin_e0_id, sin_e0_base}),
    .out_key  ({sout_id, sout_base}),
    .run_key0 (run_e0[KEY_W-1:0]),
    .run_v1   (run_e1[DESC_W-1]),
    .run_key1 (run_e1[KEY_W-1:0]),
    .st_n     (st_n),
    .store_we (store_we),
    .ev0_v    (ev0_v),
    .ev0      (ev0),
    .ev1_v    (ev1_v),
    .ev1      (ev1),
    .err      (dec_err)
  );

  est_evt_out #(.EV_W(EV_W)) u_evt (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld        (ev0_v),
    .ld_ev0    (ev0),
    .ld_ev1_v  (ev1_v),
    .ld_ev1    (ev1),
    .out_valid (evt_valid),
    .out_ready (evt_ready),
    .out_data  (ev_out)
  );

  assign evt_irq    = ev_out[EV_W-1];
  assign evt_flags  = ev_out[EV_W-2:ID_W];
  assign evt_ctx_id = ev_out[ID_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= '0;
      cur_ptr_q <= 1'b0;
      wr_ptr_q  <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      st_q  <= st_n;
      err_q <= dec_err;
      if (st_n.run_valid) begin
        cur_ptr_q <= st_n.run_idx;
        wr_ptr_q  <= !st_n.run_idx;
      end
    end
  end

  assign req_err       = err_q;
  assign st_cur_ptr    = cur_ptr_q;
  assign st_wr_ptr     = wr_ptr_q;
  assign st_el0_active = st_q.run_valid && !st_q.run_idx;
  assign st_el0_valid  = st_el0_active;
  assign st_el1_active = st_q.run_valid && st_q.run_idx;
  assign st_el1_valid  = st_el1_active;
  assign st_queue_full = st_q.pend_valid;
  assign st_ctx_id     = !st_q.run_valid ? '0 :
                         (st_q.run_sel ? run_e1[KEY_W-1:BASE_W] : run_e0[KEY_W-1:BASE_W]);

  // R11: back-pressured event stays put
  a_r11_event_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && !evt_ready) |=> (evt_valid && $stable(evt_flags) &&
                                   $stable(evt_ctx_id) && $stable(evt_irq)));

  // R9: at most one slot shown as running
  a_r9_single_active: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({st_el0_active, st_el1_active}));

  // R4: a pending slot only exists behind a running one
  a_r4_full_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    st_queue_full |-> (st_el0_active || st_el1_active));

  // R5: schedule-in on a full queue is flagged
  a_r5_full_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (sin_valid && sin_ready && st_queue_full) |=> req_err);

  // R10: a rejected request emits no event
  a_r10_err_silent: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> !evt_valid);

  // R10: a rejected request leaves the running status untouched
  a_r10_err_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> ($stable(st_ctx_id) && $stable(st_queue_full) && $stable(st_cur_ptr)));

endmodule

// File: tb/sim_exec_slot_tracker.sv
module sim_exec_slot_tracker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sin_valid = 1'b0;
  logic        sin_ready;
  logic        sin_e0_valid = 1'b0;
  logic [15:0] sin_e0_id = '0;
  logic [19:0] sin_e0_base = '0;
  logic        sin_e1_valid = 1'b0;
  logic [15:0] sin_e1_id = '0;
  logic [19:0] sin_e1_base = '0;
  logic        sout_valid = 1'b0;
  logic        sout_ready;
  logic [15:0] sout_id = '0;
  logic [19:0] sout_base = '0;
  logic        evt_valid;
  logic        evt_ready = 1'b1;
  logic [5:0]  evt_flags;
  logic [15:0] evt_ctx_id;
  logic        evt_irq;
  logic        req_err;
  logic        st_cur_ptr, st_wr_ptr, st_el0_active, st_el0_valid;
  logic        st_el1_active, st_el1_valid, st_queue_full;
  logic [15:0] st_ctx_id;

  int total = 0;
  int bad = 0;
  logic [22:0] expq[$];
  string       tagq[$];

  always #4 clk = ~clk;

  exec_slot_tracker u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // packed status: {cur, wr, el0a, el0v, el1a, el1v, qfull, ctx_id}
  task automatic chk_st(input string tag, input logic cur, input logic wr, input logic s0,
                        input logic s1, input logic qf, input logic [15:0] id);
    chk(tag, {9'd0, st_cur_ptr, st_wr_ptr, st_el0_active, st_el0_valid,
              st_el1_active, st_el1_valid, st_queue_full, st_ctx_id},
             {9'd0, cur, wr, s0, s0, s1, s1, qf, id});
  endtask

  task automatic push_ev(input string tag, input logic [5:0] f, input logic [15:0] id,
                         input logic irq);
    expq.push_back({irq, f, id});
    tagq.push_back(tag);
  endtask

  task automatic send_in(input logic v0, input logic [15:0] i0, input logic [19:0] b0,
                         input logic v1, input logic [15:0] i1, input logic [19:0] b1);
    @(posedge clk); #1;
    sin_e0_valid = v0; sin_e0_id = i0; sin_e0_base = b0;
    sin_e1_valid = v1; sin_e1_id = i1; sin_e1_base = b1;
    sin_valid = 1'b1;
    do @(negedge clk); while (!sin_ready);
    @(posedge clk); #1;
    sin_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic send_out(input logic [15:0] id, input logic [19:0] b);
    @(posedge clk); #1;
    sout_id = id; sout_base = b; sout_valid = 1'b1;
    do @(negedge clk); while (!sout_ready);
    @(posedge clk); #1;
    sout_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic drain();
    while (expq.size() != 0 || evt_valid) @(negedge clk);
  endtask

  // scoreboard monitor: an event is taken at the edge after a negedge with valid & ready
  always @(negedge clk) begin
    if (rst_n && evt_valid && evt_ready) begin
      total++;
      if (expq.size() == 0) begin
        bad++;
        $display("FAIL R11 unexpected event actual=%h expected=none",
                 {evt_irq, evt_flags, evt_ctx_id});
      end else begin
        logic [22:0] e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        if ({evt_irq, evt_flags, evt_ctx_id} !== e) begin
          bad++;
          $display("FAIL %s event actual=%h expected=%h", t,
                   {evt_irq, evt_flags, evt_ctx_id}, e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk_st("R12 status", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0);
    chk("R12 idle outputs", {29'd0, evt_valid, sin_ready, sout_ready}, {29'd0, 1'b0, 1'b1, 1'b1});

    // R2 idle schedule-in into slot 0
    push_ev("R2", 6'h01, 16'h0, 1'b1);
    send_in(1'b1, 16'h11, 20'h100, 1'b1, 16'h22, 20'h200);
    chk("R2 err", {31'd0, req_err}, 32'd0);
    drain();
    chk_st("R9 R2 status", 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 16'h11);

    // R10 wrong context scheduled out
    send_out(16'h22, 20'h200);
    chk("R10 err pulse", {31'd0, req_err}, 32'd1);
    chk_st("R10 status kept", 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 16'h11);

    // R1 same id, different base
    send_out(16'h11, 20'h101);
    chk("R1 err pulse", {31'd0, req_err}, 32'd1);
    @(negedge clk);
    chk("R1 err one cycle", {31'd0, req_err}, 32'd0);

    // R4 pending slot
    send_in(1'b1, 16'h33, 20'h300, 1'b0, 16'h0, 20'h0);
    chk("R4 err", {31'd0, req_err}, 32'd0);
    chk_st("R4 status", 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 16'h11);

    // R5 full queue rejects
    send_in(1'b1, 16'h44, 20'h400, 1'b1, 16'h55, 20'h500);
    chk("R5 err pulse", {31'd0, req_err}, 32'd1);
    chk_st("R5 status kept", 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 16'h11);

    // R6 element switch
    push_ev("R6", 6'h14, 16'h11, 1'b1);
    send_out(16'h11, 20'h100);
    drain();
    chk_st("R6 status", 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 16'h22);

    // R8 last element with pending slot
    push_ev("R8 first", 6'h18, 16'h22, 1'b0);
    push_ev("R8 second", 6'h01, 16'h0, 1'b1);
    send_out(16'h22, 20'h200);
    drain();
    chk_st("R8 status", 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 16'h33);

    // R3 condition b lite restore
    push_ev("R3 b", 6'h22, 16'h33, 1'b1);
    send_in(1'b1, 16'h33, 20'h300, 1'b0, 16'h0, 20'h0);
    drain();
    chk_st("R3 b status", 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 16'h33);

    // R7 last element, no pending
    push_ev("R7", 6'h18, 16'h33, 1'b1);
    send_out(16'h33, 20'h300);
    drain();
    chk_st("R7 R9 idle status", 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0);

    // R5 slot index follows write pointer (1)
    push_ev("R2 again", 6'h01, 16'h0, 1'b1);
    send_in(1'b1, 16'h11, 20'h100, 1'b1, 16'h22, 20'h200);
    drain();
    chk_st("R5 R9 slot1", 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 16'h11);

    push_ev("R6 again", 6'h14, 16'h11, 1'b1);
    send_out(16'h11, 20'h100);
    drain();

    // R3 condition a lite restore
    push_ev("R3 a", 6'h22, 16'h22, 1'b1);
    send_in(1'b1, 16'h22, 20'h200, 1'b1, 16'h33, 20'h300);
    drain();
    chk_st("R3 a status", 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 16'h22);

    push_ev("R6 third", 6'h14, 16'h22, 1'b1);
    send_out(16'h22, 20'h200);
    drain();
    push_ev("R7 element1", 6'h18, 16'h33, 1'b1);
    send_out(16'h33, 20'h300);
    drain();
    chk_st("R7 idle again", 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0);

    // R11 back-pressure
    @(posedge clk); #1 evt_ready = 1'b0;
    push_ev("R11 held", 6'h01, 16'h0, 1'b1);
    send_in(1'b1, 16'h11, 20'h100, 1'b0, 16'h0, 20'h0);
    chk("R11 held valid", {26'd0, evt_valid, evt_flags}, {26'd0, 1'b1, 6'h01});
    chk("R11 readies low", {30'd0, sin_ready, sout_ready}, 32'd0);
    repeat (3) @(negedge clk);
    chk("R11 still held", {9'd0, evt_valid, evt_irq, evt_flags, evt_ctx_id},
        {9'd0, 1'b1, 1'b1, 6'h01, 16'h0});

    // R11 priority: both offered, schedule-out first
    push_ev("R11 out first", 6'h18, 16'h11, 1'b1);
    push_ev("R11 in second", 6'h01, 16'h0, 1'b1);
    @(posedge clk); #1;
    evt_ready = 1'b1;
    sout_id = 16'h11; sout_base = 20'h100; sout_valid = 1'b1;
    sin_e0_valid = 1'b1; sin_e0_id = 16'h11; sin_e0_base = 20'h100;
    sin_e1_valid = 1'b0; sin_valid = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R11 priority readies", {30'd0, sin_ready, sout_ready}, {30'd0, 1'b0, 1'b1});
    @(posedge clk); #1 sout_valid = 1'b0;
    do @(negedge clk); while (!sin_ready);
    @(posedge clk); #1 sin_valid = 1'b0;
    @(negedge clk);
    drain();
    chk_st("R11 R9 final", 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 16'h11);
    chk("R11 queue empty", expq.size(), 32'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule